// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit configuration words that sits on a simple synchronous register bus and spans a 4 KB byte window. Most of the bank is protected. A write to a protected word lands only when the bank has been unlocked, and unlocking takes a write of a 16-bit magic key to a dedicated disarm address. A different key, written to a separate arm address, restores the protection. A key that does not match is dropped without any sign on the bus. Software reads the current lock state from a status word. One 1-bit control word stays writable at all times.

The protected space holds three groups of words, each with its own reset defaults: a clock-generator group, a reset-control group and a memory-interface group. Some offsets in these groups are read-only, one is a hole, and one always reads as a constant. Every other offset reads as zero and drops writes. A write that is dropped because the bank is locked, or because the offset is read-only or unmapped, raises a one-cycle error pulse. Only word-aligned addresses are decoded.

The bus carries no streams and has no back-pressure. Writes complete in the cycle they are presented. Read data appears exactly one cycle after the read strobe.

Top module: `keyed_ctrl_bank`

## Requirements
- R1: A write to byte offset 0x8 clears the lock state when bits 15:0 of the write data equal 0xDF0D. Any other value leaves the lock state unchanged.
- R2: A write to byte offset 0x4 sets the lock state when bits 15:0 of the write data equal 0x767B. Any other value leaves the lock state unchanged.
- R3: After reset the bank is locked and the control word reads 0. The clock-generator words read as follows: 0x100, 0x104 and 0x108 read 0x0001A008, 0x10C reads 0x0000003F, 0x110, 0x114 and 0x118 read 0x00014000, and 0x11C reads 0. In the reset-control group, 0x23C reads 0x01F33F0F and 0x248 reads 0x00000040. All other mapped words read 0.
- R4: A read of offset 0xC returns the lock state in bit 0 with zeros above it, and a write there changes nothing. Reads of 0x4 and 0x8 return zero.
- R5: Offset 0x0 stores bit 0 of the write data and reads it back in bit 0, whether the bank is locked or not. Writes to 0x0, 0x4, 0x8 and 0xC never raise the error pulse.
- R6: While the bank is locked, a write to any offset of 0x10 or above changes no register, and the error output is high in the following cycle.
- R7: While the bank is unlocked, a full 32-bit write to a writable word of 0x100–0x11C, 0x200–0x258 or 0x600–0x620 is stored and reads back unchanged.
- R8: Offset 0x10C is read-only. Even when unlocked, a write to it keeps its value and raises the error pulse.
- R9: Offset 0x25C always reads 1. Writes to 0x25C and 0x250 are rejected with the error pulse even when unlocked, and 0x250 keeps its value.
- R10: Offset 0x604 is a hole: it reads zero, and a write to it raises the error pulse.
- R11: Any offset outside the ranges above reads zero, and a write to it raises the error pulse.
- R12: Read data is registered: it holds the addressed value in the cycle after the read strobe and zero in any cycle that follows no read. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_re |
| wr_err | output | 1 | One-cycle pulse for a dropped write |

## Verification
The assertions assume that the bus inputs are always known values and change only between clock edges. They also assume that the key field means something only when the write strobe is high. The bench drives every bus input on the falling edge from a single task, so nothing is ever left undriven. It holds both strobes low through reset. In any one cycle it issues a read or a write, never both, so each expected read value comes from a single model state.

// File: rtl/ctrl_bank_pkg.sv
package ctrl_bank_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int WORD_W = ADDR_W - 2;

  localparam logic [15:0] KEY_ARM    = 16'h767B;
  localparam logic [15:0] KEY_DISARM = 16'hDF0D;

  localparam logic [WORD_W-1:0] W_CTRL   = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_ARM    = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_DISARM = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_STATE  = WORD_W'(3);
  localparam logic [WORD_W-1:0] W_ONE    = WORD_W'('h97);

  localparam int CLKG_BASE = 'h40;
  localparam int CLKG_N    = 8;
  localparam int RSTC_BASE = 'h80;
  localparam int RSTC_N    = 23;
  localparam int MEMI_BASE = 'h180;
  localparam int MEMI_N    = 9;

  localparam logic [CLKG_N-1:0] CLKG_WR = ~(CLKG_N'(1) << 3);
  localparam logic [CLKG_N-1:0] CLKG_RD = {CLKG_N{1'b1}};
  localparam logic [RSTC_N-1:0] RSTC_WR = ~(RSTC_N'(1) << 20);
  localparam logic [RSTC_N-1:0] RSTC_RD = {RSTC_N{1'b1}};
  localparam logic [MEMI_N-1:0] MEMI_WR = ~(MEMI_N'(1) << 1);
  localparam logic [MEMI_N-1:0] MEMI_RD = ~(MEMI_N'(1) << 1);

  function automatic logic [CLKG_N*DATA_W-1:0] clkg_init();
    logic [CLKG_N*DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < CLKG_N; i++) begin
      if (i < 3)      v[i*DATA_W +: DATA_W] = 32'h0001_A008;
      else if (i == 3) v[i*DATA_W +: DATA_W] = 32'h0000_003F;
      else if (i < 7) v[i*DATA_W +: DATA_W] = 32'h0001_4000;
    end
    return v;
  endfunction

  function automatic logic [RSTC_N*DATA_W-1:0] rstc_init();
    logic [RSTC_N*DATA_W-1:0] v;
    v = '0;
    v[15*DATA_W +: DATA_W] = 32'h01F3_3F0F;
    v[18*DATA_W +: DATA_W] = 32'h0000_0040;
    return v;
  endfunction
endpackage

// File: rtl/key_lock.sv
module key_lock
  import ctrl_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word_addr,
  input  logic [15:0]       key,
  output logic              locked
);
  logic arm_hit, disarm_hit;

  assign arm_hit    = wr_en && (word_addr == W_ARM)    && (key == KEY_ARM);
  assign disarm_hit = wr_en && (word_addr == W_DISARM) && (key == KEY_DISARM);

  always_ff @(posedge clk) begin
    if (!rst_n)          locked <= 1'b1;
    else if (arm_hit)    locked <= 1'b1;
    else if (disarm_hit) locked <= 1'b0;
  end
endmodule

// File: rtl/reg_group.sv
module reg_group #(
  parameter int WORD_W = 10,
  parameter int DATA_W = 32,
  parameter int BASE   = 0,
  parameter int N      = 4,
  parameter logic [N*DATA_W-1:0] INIT = '0,
  parameter logic [N-1:0] WR_MASK = '1,
  parameter logic [N-1:0] RD_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_addr,
  input  logic              wr_go,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_ok,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic              in_range;
  logic [WORD_W-1:0] offs;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] word_q [N];

  assign in_range = (word_addr >= WORD_W'(BASE)) && (word_addr < WORD_W'(BASE + N));
  assign offs     = word_addr - WORD_W'(BASE);
  assign idx      = offs[IDX_W-1:0];

  for (genvar i = 0; i < N; i++) begin : g_word
    if (WR_MASK[i]) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)
          word_q[i] <= INIT[i*DATA_W +: DATA_W];
        else if (wr_go && in_range && idx == IDX_W'(i))
          word_q[i] <= wdata;
      end
    end else begin : g_ro
      assign word_q[i] = INIT[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    wr_ok = 1'b0;
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (in_range && idx == IDX_W'(i)) begin
        wr_ok = WR_MASK[i];
        if (RD_MASK[i]) rdata = word_q[i];
      end
    end
  end
endmodule

// File: rtl/keyed_ctrl_bank.sv
module keyed_ctrl_bank
  import ctrl_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wr_err
);
  logic [WORD_W-1:0] word;
  logic              sys_word;
  logic              locked;
  logic              ctrl_q;
  logic              wr_commit;
  logic              ok_clkg, ok_rstc, ok_memi, any_ok;
  logic [DATA_W-1:0] rd_clkg, rd_rstc, rd_memi, rd_next;
  logic              unused_addr_bits;

  assign word             = bus_addr[ADDR_W-1:2];
  assign unused_addr_bits = ^bus_addr[1:0];
  assign sys_word         = (word <= W_STATE);
  assign any_ok           = ok_clkg | ok_rstc | ok_memi;
  assign wr_commit        = bus_we && !sys_word && !locked && any_ok;

  key_lock u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .word_addr(word),
    .key(bus_wdata[15:0]), .locked(locked)
  );

  reg_group #(.WORD_W(WORD_W), .DATA_W(DATA_W), .BASE(CLKG_BASE), .N(CLKG_N),
              .INIT(clkg_init()), .WR_MASK(CLKG_WR), .RD_MASK(CLKG_RD)) u_clkg (
    .clk(clk), .rst_n(rst_n), .word_addr(word), .wr_go(wr_commit),
    .wdata(bus_wdata), .wr_ok(ok_clkg), .rdata(rd_clkg)
  );

  reg_group #(.WORD_W(WORD_W), .DATA_W(DATA_W), .BASE(RSTC_BASE), .N(RSTC_N),
              .INIT(rstc_init()), .WR_MASK(RSTC_WR), .RD_MASK(RSTC_RD)) u_rstc (
    .clk(clk), .rst_n(rst_n), .word_addr(word), .wr_go(wr_commit),
    .wdata(bus_wdata), .wr_ok(ok_rstc), .rdata(rd_rstc)
  );

  reg_group #(.WORD_W(WORD_W), .DATA_W(DATA_W), .BASE(MEMI_BASE), .N(MEMI_N),
              .INIT('0), .WR_MASK(MEMI_WR), .RD_MASK(MEMI_RD)) u_memi (
    .clk(clk), .rst_n(rst_n), .word_addr(word), .wr_go(wr_commit),
    .wdata(bus_wdata), .wr_ok(ok_memi), .rdata(rd_memi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctrl_q <= 1'b0;
    else if (bus_we && word == W_CTRL) ctrl_q <= bus_wdata[0];
  end

  always_comb begin
    if (word == W_CTRL)       rd_next = {{(DATA_W-1){1'b0}}, ctrl_q};
    else if (word == W_STATE) rd_next = {{(DATA_W-1){1'b0}}, locked};
    else if (word == W_ONE)   rd_next = DATA_W'(1);
    else                      rd_next = rd_clkg | rd_rstc | rd_memi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      wr_err    <= 1'b0;
    end else begin
      bus_rdata <= bus_re ? rd_next : '0;
      wr_err    <= bus_we && !sys_word && (locked || !any_ok);
    end
  end
endmodule

// File: rtl/ctrl_bank_chk.sv
module ctrl_bank_chk
  import ctrl_bank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wr_err,
  input logic              locked
);
  logic [WORD_W-1:0] w;
  assign w = bus_addr[ADDR_W-1:2];

  // R1
  disarm_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && w == W_DISARM && bus_wdata[15:0] == KEY_DISARM) |=> !locked);

  // R2
  arm_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && w == W_ARM && bus_wdata[15:0] == KEY_ARM) |=> locked);

  // R1
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (w == W_ARM || w == W_DISARM)) |=> $stable(locked));

  // R4
  state_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && w == W_STATE) |=> bus_rdata == {{(DATA_W-1){1'b0}}, $past(locked)});

  // R5
  sys_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && w <= W_STATE) |=> !wr_err);

  // R6
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && locked && w > W_STATE) |=> wr_err);

  // R12
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == '0);
endmodule

bind keyed_ctrl_bank ctrl_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .wr_err(wr_err), .locked(locked)
);

// File: tb/keyed_ctrl_bank_tb.sv
module keyed_ctrl_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we, bus_re;
  logic [31:0] bus_wdata, bus_rdata;
  logic        wr_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] mdl [int];
  bit mlock, mctrl;

  always #2 clk = ~clk;

  keyed_ctrl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .wr_err(wr_err)
  );

  function automatic void mdl_reset();
    mdl.delete();
    mlock = 1'b1;
    mctrl = 1'b0;
    for (int w = 'h40; w <= 'h47; w++) mdl[w] = 32'h0;
    mdl['h40] = 32'h0001A008; mdl['h41] = 32'h0001A008; mdl['h42] = 32'h0001A008;
    mdl['h43] = 32'h0000003F;
    mdl['h44] = 32'h00014000; mdl['h45] = 32'h00014000; mdl['h46] = 32'h00014000;
    for (int w = 'h80; w <= 'h96; w++) mdl[w] = 32'h0;
    mdl['h8F] = 32'h01F33F0F;
    mdl['h92] = 32'h00000040;
    for (int w = 'h180; w <= 'h188; w++) if (w != 'h181) mdl[w] = 32'h0;
  endfunction

  function automatic bit writable(int w);
    return (w >= 'h40 && w <= 'h47 && w != 'h43) ||
           (w >= 'h80 && w <= 'h96 && w != 'h94) ||
           (w >= 'h180 && w <= 'h188 && w != 'h181);
  endfunction

  function automatic logic [31:0] mread(int w);
    if (w == 0) return {31'b0, mctrl};
    if (w == 3) return {31'b0, mlock};
    if (w == 'h97) return 32'd1;
    if (mdl.exists(w)) return mdl[w];
    return 32'h0;
  endfunction

  task automatic op(input bit we, input bit re, input logic [11:0] a,
                    input logic [31:0] d, input string tag);
    logic [31:0] erd;
    bit eerr;
    int w;
    w = int'(a >> 2);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
    erd  = re ? mread(w) : 32'h0;
    eerr = 1'b0;
    if (we) begin
      if (w == 0) mctrl = d[0];
      else if (w == 1) begin if (d[15:0] == 16'h767B) mlock = 1'b1; end
      else if (w == 2) begin if (d[15:0] == 16'hDF0D) mlock = 1'b0; end
      else if (w == 3) begin end
      else if (mlock) eerr = 1'b1;
      else if (writable(w)) mdl[w] = d;
      else eerr = 1'b1;
    end
    @(negedge clk);
    checks++;
    if (bus_rdata !== erd || wr_err !== eerr) begin
      fails++;
      $display("FAIL %s addr=%h rdata=%h exp=%h err=%b exp=%b",
               tag, a, bus_rdata, erd, wr_err, eerr);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    op(1'b1, 1'b0, a, d, tag);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    op(1'b0, 1'b1, a, 32'h0, tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R12 actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (bus_rdata !== 32'h0 || wr_err !== 1'b0) begin
      fails++;
      $display("FAIL R3 reset outputs rdata=%h exp=0 err=%b exp=0", bus_rdata, wr_err);
    end
    rst_n = 1'b1;
    mdl_reset();

    // R3 reset defaults
    rd(12'h00C, "R3"); rd(12'h000, "R3"); rd(12'h100, "R3"); rd(12'h108, "R3");
    rd(12'h10C, "R3"); rd(12'h114, "R3"); rd(12'h11C, "R3"); rd(12'h23C, "R3");
    rd(12'h248, "R3"); rd(12'h600, "R3");
    // R4 arm/disarm offsets read zero
    rd(12'h004, "R4"); rd(12'h008, "R4");
    // R6 locked writes dropped
    wr(12'h100, 32'hDEAD_BEEF, "R6"); rd(12'h100, "R6");
    wr(12'h620, 32'h1234_5678, "R6"); rd(12'h620, "R6");
    // R5 control word while locked
    wr(12'h000, 32'hFFFF_FFFF, "R5"); rd(12'h000, "R5");
    wr(12'h000, 32'hFFFF_FFFE, "R5"); rd(12'h000, "R5");
    // R1 wrong disarm keys
    wr(12'h008, 32'h0000_767B, "R1"); rd(12'h00C, "R1");
    wr(12'h004, 32'h0000_DF0D, "R1"); rd(12'h00C, "R1");
    // R1 correct key with junk upper bits
    wr(12'h008, 32'hABCD_DF0D, "R1"); rd(12'h00C, "R1");
    // R4 write to state ignored
    wr(12'h00C, 32'hFFFF_FFFF, "R4"); rd(12'h00C, "R4");
    // R7 unlocked writes
    wr(12'h100, 32'hCAFE_0001, "R7"); rd(12'h100, "R7");
    wr(12'h11C, 32'h8000_0001, "R7"); rd(12'h11C, "R7");
    wr(12'h200, 32'h0F0F_F0F0, "R7"); rd(12'h200, "R7");
    wr(12'h258, 32'hFFFF_FFFF, "R7"); rd(12'h258, "R7");
    wr(12'h620, 32'h5A5A_A5A5, "R7"); rd(12'h620, "R7");
    wr(12'h600, 32'h0000_0001, "R7"); rd(12'h600, "R7");
    // R8 read-only status
    wr(12'h10C, 32'h0, "R8"); rd(12'h10C, "R8");
    // R9 constant one and rejected word
    wr(12'h250, 32'h1111_1111, "R9"); rd(12'h250, "R9");
    wr(12'h25C, 32'h0, "R9"); rd(12'h25C, "R9");
    // R10 hole
    wr(12'h604, 32'h7777_7777, "R10"); rd(12'h604, "R10");
    // R11 unmapped
    wr(12'h010, 32'h1, "R11"); rd(12'h010, "R11");
    wr(12'hFFC, 32'h1, "R11"); rd(12'hFFC, "R11");
    wr(12'h120, 32'h1, "R11"); rd(12'h624, "R11");
    // R12 low address bits ignored, idle gives zero
    rd(12'h103, "R12"); rd(12'h23E, "R12");
    op(1'b0, 1'b0, 12'h100, 32'h0, "R12");
    // R2 wrong arm key then correct
    wr(12'h004, 32'h0000_767C, "R2"); rd(12'h00C, "R2");
    wr(12'h004, 32'h1234_767B, "R2"); rd(12'h00C, "R2");
    // R6 relocked
    wr(12'h200, 32'h0, "R6"); rd(12'h200, "R6");
    wr(12'h010, 32'h0, "R6");
    op(1'b0, 1'b0, 12'h0, 32'h0, "R12");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule